// File: doc/BRIEF.md
# One-Wire Bit-Slot Bus Master

This block drives a one-wire bus through an open-drain pad: it pulls the line low when its drive output is high and reads the line back through a separate input. It produces three kinds of bus activity: a reset pulse followed by a presence check, a write-0 slot, and a combined write-1/read slot. All bus timing is measured in microseconds. A programmable divider produces the microsecond tick from the peripheral clock.

Software controls the block through a small 16-bit register port. It programs the divider once. To start an operation it writes a command bit into the control word. It then polls that word until the command bit clears. When the operation ends, the presence result and the sampled read bit remain in the same control word. A separate soft-reset register aborts any operation at once. The line input passes through a two-stage synchronizer before it is sampled.

Top module: `onewire_bit_master`

## Requirements
- R1: After reset the control word (offset 0) reads 0x0040, the divider (offset 2) reads 0, offset 4 and unused offsets read 0, and the line is released.
- R2: The divider register holds N-1. Each microsecond of an operation lasts N clocks, counted from the clock edge that accepts the command.
- R3: Writing control with bit 7 set starts a reset sequence. The line is driven low for 480 µs and then released. Bit 7 reads 1 until 960 µs, then clears.
- R4: During a reset sequence the synchronized line is sampled 70 µs after release (550 µs after start) into control bit 6, where 0 means a device answered. Only reset sequences change bit 6.
- R5: Control bit 5 starts a write-0 slot. The line is low for 60 µs, and bit 5 reads 1 until 70 µs.
- R6: Control bit 4 starts a write-1/read slot. The line is low for 6 µs, and the synchronized line is sampled at 15 µs into control bit 3. Bit 4 reads 1 until 70 µs. Only read slots change bit 3.
- R7: A control write accepted while any command bit reads 1 has no effect, including a write that arrives on the edge where the operation completes.
- R8: When several command bits are written together, bit 7 wins over bit 5, and bit 5 wins over bit 4. A control write with none of bits 7, 5 and 4 set starts nothing.
- R9: The divider reads back what was written. Divider writes made while an operation is running are ignored.
- R10: Writing 1 to bit 0 at offset 4 aborts at once. The line is released, all command bits clear, bit 6 returns to 1 and bit 3 returns to 0. The divider keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register byte offset (0 control, 2 divider, 4 soft reset) |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Read data for the addressed register, combinational |
| ow_drive_low | output | 1 | High to pull the one-wire line low |
| ow_line_in | input | 1 | Level observed on the one-wire line |

## Verification
The key overlap is a new command that arrives on the same clock edge where the running operation finishes. On that edge the busy state still holds, so the command must be dropped, and a write one cycle later would be accepted. The bench provokes this case by counting clocks from the accepted command to its completion edge under a fast divider, and timing the next write to land exactly on that edge. The per-cycle reference model and an explicit check both require every command bit to read 0 on the following cycle. A second overlap pairs a soft-reset write with an active reset sequence; here the abort must win over both the running timer and the pending presence sample.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RST  = 2'd1,
    OP_WR0  = 2'd2,
    OP_WR1  = 2'd3
  } owm_op_e;

  // control word bit positions (software decodes these)
  localparam int BIT_RST  = 7;
  localparam int BIT_PRES = 6;
  localparam int BIT_WR0  = 5;
  localparam int BIT_WR1  = 4;
  localparam int BIT_RDV  = 3;
  localparam int BIT_ABRT = 0;

  // register byte offsets
  localparam int OFS_CTRL = 0;
  localparam int OFS_DIV  = 2;
  localparam int OFS_SRST = 4;

endpackage

// File: rtl/owm_tick_gen.sv
module owm_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] pre_d;

  always_comb begin
    tick = run && (pre_q == div);
    if (!run || tick) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

endmodule

// File: rtl/owm_slot_seq.sv
module owm_slot_seq
  import owm_pkg::*;
#(
  parameter int RST_LOW_US = 480,
  parameter int RST_SMP_US = 70,
  parameter int RST_REC_US = 480,
  parameter int W0_LOW_US  = 60,
  parameter int W1_LOW_US  = 6,
  parameter int W1_SMP_US  = 15,
  parameter int SLOT_US    = 70
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    start,
  input  owm_op_e start_op,
  input  logic    abort,
  output owm_op_e op_q,
  output logic    drive_low,
  output logic    pres_upd,
  output logic    bit_upd
);

  localparam int RST_SMP_AT = RST_LOW_US + RST_SMP_US;
  localparam int RST_END    = RST_LOW_US + RST_REC_US;
  localparam int US_W       = $clog2(RST_END + 1);

  localparam logic [US_W-1:0] C_RST_LOW = US_W'(RST_LOW_US);
  localparam logic [US_W-1:0] C_RST_SMP = US_W'(RST_SMP_AT);
  localparam logic [US_W-1:0] C_RST_END = US_W'(RST_END);
  localparam logic [US_W-1:0] C_W0_LOW  = US_W'(W0_LOW_US);
  localparam logic [US_W-1:0] C_W1_LOW  = US_W'(W1_LOW_US);
  localparam logic [US_W-1:0] C_W1_SMP  = US_W'(W1_SMP_US);
  localparam logic [US_W-1:0] C_SLOT    = US_W'(SLOT_US);

  owm_op_e         op_d;
  logic [US_W-1:0] us_q;
  logic [US_W-1:0] us_d;
  logic [US_W-1:0] us_inc;
  logic [US_W-1:0] end_us;

  always_comb begin
    us_inc = us_q + US_W'(1);
    end_us = (op_q == OP_RST) ? C_RST_END : C_SLOT;
  end

  // next-state
  always_comb begin
    op_d     = op_q;
    us_d     = us_q;
    pres_upd = 1'b0;
    bit_upd  = 1'b0;
    if (abort) begin
      op_d = OP_IDLE;
      us_d = '0;
    end else if (op_q == OP_IDLE) begin
      if (start) begin
        op_d = start_op;
        us_d = '0;
      end
    end else if (tick) begin
      us_d     = us_inc;
      pres_upd = (op_q == OP_RST) && (us_inc == C_RST_SMP);
      bit_upd  = (op_q == OP_WR1) && (us_inc == C_W1_SMP);
      if (us_inc == end_us) begin
        op_d = OP_IDLE;
        us_d = '0;
      end
    end
  end

  always_comb begin
    case (op_q)
      OP_RST:  drive_low = (us_q < C_RST_LOW);
      OP_WR0:  drive_low = (us_q < C_W0_LOW);
      OP_WR1:  drive_low = (us_q < C_W1_LOW);
      default: drive_low = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_IDLE;
      us_q <= '0;
    end else begin
      op_q <= op_d;
      us_q <= us_d;
    end
  end

endmodule

// File: rtl/owm_regs.sv
module owm_regs
  import owm_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  owm_op_e           op_q,
  input  logic              pres_upd,
  input  logic              bit_upd,
  input  logic              smp_val,
  output logic [DIV_W-1:0]  div_q,
  output logic              start,
  output owm_op_e           start_op,
  output logic              abort,
  output logic [DATA_W-1:0] rdata
);

  logic             busy;
  logic             hit_ctrl;
  logic             hit_div;
  logic             hit_srst;
  logic             pres_q;
  logic             pres_d;
  logic             rdv_q;
  logic             rdv_d;
  logic [DIV_W-1:0] div_d;
  logic [DATA_W-1:0] ctrl_w;

  always_comb begin
    busy     = (op_q != OP_IDLE);
    hit_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
    hit_div  = wr_en && (addr == ADDR_W'(OFS_DIV));
    hit_srst = wr_en && (addr == ADDR_W'(OFS_SRST));
    abort    = hit_srst && wdata[BIT_ABRT];

    // fixed priority: reset, then write-0, then write-1/read
    start_op = OP_IDLE;
    if (wdata[BIT_RST]) begin
      start_op = OP_RST;
    end else if (wdata[BIT_WR0]) begin
      start_op = OP_WR0;
    end else if (wdata[BIT_WR1]) begin
      start_op = OP_WR1;
    end
    start = hit_ctrl && !busy && (start_op != OP_IDLE);
  end

  // next-state for status and divider
  always_comb begin
    pres_d = pres_q;
    rdv_d  = rdv_q;
    div_d  = div_q;
    if (abort) begin
      pres_d = 1'b1;
      rdv_d  = 1'b0;
    end else begin
      if (pres_upd) pres_d = smp_val;
      if (bit_upd)  rdv_d  = smp_val;
    end
    if (hit_div && !busy) begin
      div_d = wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q <= 1'b1;
      rdv_q  <= 1'b0;
      div_q  <= '0;
    end else begin
      pres_q <= pres_d;
      rdv_q  <= rdv_d;
      div_q  <= div_d;
    end
  end

  always_comb begin
    ctrl_w           = '0;
    ctrl_w[BIT_RST]  = (op_q == OP_RST);
    ctrl_w[BIT_PRES] = pres_q;
    ctrl_w[BIT_WR0]  = (op_q == OP_WR0);
    ctrl_w[BIT_WR1]  = (op_q == OP_WR1);
    ctrl_w[BIT_RDV]  = rdv_q;
    if (addr == ADDR_W'(OFS_CTRL)) begin
      rdata = ctrl_w;
    end else if (addr == ADDR_W'(OFS_DIV)) begin
      rdata = DATA_W'(div_q);
    end else begin
      rdata = '0;
    end
  end

endmodule

// File: rtl/onewire_bit_master.sv
module onewire_bit_master
  import owm_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 16,
  parameter int DIV_W      = 16,
  parameter int RST_LOW_US = 480,
  parameter int RST_SMP_US = 70,
  parameter int RST_REC_US = 480,
  parameter int W0_LOW_US  = 60,
  parameter int W1_LOW_US  = 6,
  parameter int W1_SMP_US  = 15,
  parameter int SLOT_US    = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ow_drive_low,
  input  logic              ow_line_in
);

  logic [1:0]       rsync_q;
  logic             core_rst_n;
  logic [1:0]       lsync_q;
  logic             tick;
  logic             start;
  logic             abort;
  logic             pres_upd;
  logic             bit_upd;
  owm_op_e          start_op;
  owm_op_e          op_q;
  logic [DIV_W-1:0] div_q;

  // reset: asserted at once, released after two clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign core_rst_n = rsync_q[1];

  // line input synchronizer, idles at the released level
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      lsync_q <= 2'b11;
    end else begin
      lsync_q <= {lsync_q[0], ow_line_in};
    end
  end

  owm_tick_gen #(
    .DIV_W (DIV_W)
  ) u_tick (
    .clk   (clk),
    .rst_n (core_rst_n),
    .run   (op_q != OP_IDLE),
    .div   (div_q),
    .tick  (tick)
  );

  owm_slot_seq #(
    .RST_LOW_US (RST_LOW_US),
    .RST_SMP_US (RST_SMP_US),
    .RST_REC_US (RST_REC_US),
    .W0_LOW_US  (W0_LOW_US),
    .W1_LOW_US  (W1_LOW_US),
    .W1_SMP_US  (W1_SMP_US),
    .SLOT_US    (SLOT_US)
  ) u_seq (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .tick      (tick),
    .start     (start),
    .start_op  (start_op),
    .abort     (abort),
    .op_q      (op_q),
    .drive_low (ow_drive_low),
    .pres_upd  (pres_upd),
    .bit_upd   (bit_upd)
  );

  owm_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DIV_W  (DIV_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .wr_en    (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .op_q     (op_q),
    .pres_upd (pres_upd),
    .bit_upd  (bit_upd),
    .smp_val  (lsync_q[1]),
    .div_q    (div_q),
    .start    (start),
    .start_op (start_op),
    .abort    (abort),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/owm_checker.sv
module owm_checker
  import owm_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DIV_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        cmd_bits,
  input owm_op_e           op_q,
  input logic [DIV_W-1:0]  div_q,
  input logic              drive_low,
  input logic              tick
);

  // cmd_bits = {bit7, bit5, bit4, bit0} of the write data
  logic wr_ctrl;
  logic wr_srst;
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_srst = bus_wr && (bus_addr == ADDR_W'(OFS_SRST));

  assert_drive_needs_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low |-> (op_q != OP_IDLE));

  assert_tick_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (op_q != OP_IDLE));

  assert_busy_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && op_q != OP_IDLE) |=> (op_q == $past(op_q) || op_q == OP_IDLE));

  assert_reset_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && op_q == OP_IDLE && cmd_bits[3]) |=> (op_q == OP_RST));

  assert_wr0_over_wr1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && op_q == OP_IDLE && !cmd_bits[3] && cmd_bits[2]) |=> (op_q == OP_WR0));

  assert_no_cmd_stays_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_IDLE && !(wr_ctrl && (cmd_bits[3] || cmd_bits[2] || cmd_bits[1])))
      |=> (op_q == OP_IDLE));

  assert_abort_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_srst && cmd_bits[0]) |=> (op_q == OP_IDLE && !drive_low));

  assert_div_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q != OP_IDLE && $past(op_q) != OP_IDLE) |-> $stable(div_q));

endmodule

bind onewire_bit_master owm_checker #(
  .ADDR_W (ADDR_W),
  .DIV_W  (DIV_W)
) u_owm_checker (
  .clk       (clk),
  .rst_n     (core_rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .cmd_bits  ({bus_wdata[7], bus_wdata[5], bus_wdata[4], bus_wdata[0]}),
  .op_q      (op_q),
  .div_q     (div_q),
  .drive_low (ow_drive_low),
  .tick      (tick)
);

// File: tb/onewire_bit_master_bench.sv
module onewire_bit_master_bench;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        ow_drive_low;
  logic        ow_line_in;
  logic        dev_pull;

  int n_chk;
  int n_bad;
  int cyc;
  bit cmp_on;
  bit done;

  // reference model state
  int m_op;   // 0 idle, 1 reset, 2 write-0, 3 write-1/read
  int m_el;   // edges since the accepting edge
  int m_n;
  int m_div;
  int m_pres;
  int m_rdv;
  int h1;
  int h2;

  assign ow_line_in = !(ow_drive_low || dev_pull);

  onewire_bit_master u_onewire_bit_master (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .ow_drive_low (ow_drive_low),
    .ow_line_in   (ow_line_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int low_us(int op);
    if (op == 1) return 480;
    if (op == 2) return 60;
    if (op == 3) return 6;
    return 0;
  endfunction

  function automatic int end_us(int op);
    return (op == 1) ? 960 : 70;
  endfunction

  function automatic int m_low();
    return (m_op != 0 && m_el < low_us(m_op) * m_n) ? 1 : 0;
  endfunction

  function automatic int exp_rdata(int a);
    int v;
    v = 0;
    if (a == 0) begin
      if (m_op == 1) v = v | 16'h0080;
      if (m_pres != 0) v = v | 16'h0040;
      if (m_op == 2) v = v | 16'h0020;
      if (m_op == 3) v = v | 16'h0010;
      if (m_rdv != 0) v = v | 16'h0008;
    end else if (a == 2) begin
      v = m_div;
    end
    return v;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // reference model, advanced on every rising edge from bench-driven inputs
  always @(posedge clk) begin
    int line_now;
    int smp;
    int was_busy;
    if (!rst_n) begin
      m_op = 0; m_el = 0; m_n = 1; m_div = 0; m_pres = 1; m_rdv = 0;
      h1 = 1; h2 = 1;
    end else begin
      line_now = (m_low() != 0 || dev_pull) ? 0 : 1;
      smp = h2;
      h2 = h1;
      h1 = line_now;
      was_busy = (m_op != 0) ? 1 : 0;
      if (m_op != 0) begin
        m_el = m_el + 1;
        if (m_op == 1 && m_el == 550 * m_n) m_pres = smp;
        if (m_op == 3 && m_el == 15 * m_n) m_rdv = smp;
        if (m_el == end_us(m_op) * m_n) m_op = 0;
      end
      if (bus_wr) begin
        if (bus_addr == 3'd0 && was_busy == 0) begin
          if (bus_wdata[7]) m_op = 1;
          else if (bus_wdata[5]) m_op = 2;
          else if (bus_wdata[4]) m_op = 3;
          if (m_op != 0) begin
            m_el = 0;
            m_n = m_div + 1;
          end
        end else if (bus_addr == 3'd2 && was_busy == 0) begin
          m_div = int'(bus_wdata);
        end else if (bus_addr == 3'd4 && bus_wdata[0]) begin
          m_op = 0; m_el = 0; m_pres = 1; m_rdv = 0;
        end
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    string tag;
    if (cmp_on && !done) begin
      tag = (m_op == 1) ? "R3" : (m_op == 2) ? "R5" : (m_op == 3) ? "R6" : "R1";
      check({tag, " line"}, int'(ow_drive_low), m_low());
      check({tag, " rdata"}, int'(bus_rdata), exp_rdata(int'(bus_addr)));
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1: actual=hung expected=finished");
      finish_up();
    end
  end

  task automatic bus_write(int a, int d);
    @(posedge clk); #2;
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 16'(d);
    @(posedge clk); #2;
    bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = 16'd0;
  endtask

  task automatic bus_read(int a, output int d);
    @(posedge clk); #2;
    bus_addr = 3'(a);
    @(negedge clk);
    d = int'(bus_rdata);
    @(posedge clk); #2;
    bus_addr = 3'd0;
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // count line-low and busy negedges until all command bits drop
  task automatic run_idle(output int low_cnt, output int busy_cnt);
    low_cnt = 0;
    busy_cnt = 0;
    forever begin
      @(negedge clk);
      if ((bus_rdata & 16'h00B0) == 0) break;
      busy_cnt++;
      if (ow_drive_low) low_cnt++;
    end
    #2;
  endtask

  initial begin
    int rd;
    int lc;
    int bc;
    n_chk = 0; n_bad = 0; cyc = 0; cmp_on = 0; done = 0;
    bus_wr = 0; bus_addr = 0; bus_wdata = 0; dev_pull = 0;
    rst_n = 0;
    cycles(4);
    rst_n = 1;
    cycles(4);
    cmp_on = 1;

    // R1 reset state
    bus_read(0, rd); check("R1 ctrl after reset", rd, 16'h0040);
    bus_read(2, rd); check("R1 divider after reset", rd, 0);
    bus_read(4, rd); check("R1 soft-reset reads 0", rd, 0);
    bus_read(6, rd); check("R1 unused offset", rd, 0);
    check("R1 line released", int'(ow_drive_low), 0);

    // R9 divider: N = 5
    bus_write(2, 4);
    bus_read(2, rd); check("R9 divider readback", rd, 4);

    // R3/R4 reset with a device answering; R7 write while busy
    bus_write(0, 16'h0080);
    @(negedge clk);
    check("R3 busy bit set", int'(bus_rdata & 16'h00B0), 16'h0080);
    check("R3 line low", int'(ow_drive_low), 1);
    #2;
    bus_write(0, 16'h0020);
    @(negedge clk);
    check("R7 busy write dropped", int'(bus_rdata & 16'h00B0), 16'h0080);
    #2;
    cycles(500 * 5);
    dev_pull = 1;
    cycles(100 * 5);
    dev_pull = 0;
    run_idle(lc, bc);
    check("R4 presence seen", int'(bus_rdata), 16'h0000);

    // R3/R4 reset without device; exact timing at N=5
    bus_write(0, 16'h0080);
    run_idle(lc, bc);
    check("R3 reset low length", lc, 480 * 5);
    check("R3 reset busy length", bc, 960 * 5);
    check("R4 no device", int'(bus_rdata), 16'h0040);

    // R6 read slot, line stays high
    bus_write(0, 16'h0010);
    run_idle(lc, bc);
    check("R6 read low length", lc, 6 * 5);
    check("R6 read busy length", bc, 70 * 5);
    check("R6 read one", int'(bus_rdata), 16'h0048);

    // R5 write-0 slot keeps the read bit
    bus_write(0, 16'h0020);
    run_idle(lc, bc);
    check("R5 write0 low length", lc, 60 * 5);
    check("R5 write0 busy length", bc, 70 * 5);
    check("R5 status kept", int'(bus_rdata), 16'h0048);

    // R6 read slot, device pulls low
    bus_write(0, 16'h0010);
    cycles(8 * 5);
    dev_pull = 1;
    cycles(30 * 5);
    dev_pull = 0;
    run_idle(lc, bc);
    check("R6 read zero", int'(bus_rdata), 16'h0040);

    // R9 divider write while busy is ignored
    bus_write(0, 16'h0010);
    bus_write(2, 9);
    run_idle(lc, bc);
    bus_read(2, rd); check("R9 busy divider write ignored", rd, 4);

    // R8 priority write-0 over write-1
    bus_write(0, 16'h0030);
    @(negedge clk);
    check("R8 write0 wins", int'(bus_rdata & 16'h00B0), 16'h0020);
    #2;
    run_idle(lc, bc);

    // prepare status: presence 0 and read bit 1
    bus_write(0, 16'h0080);
    cycles(500 * 5);
    dev_pull = 1;
    cycles(100 * 5);
    dev_pull = 0;
    run_idle(lc, bc);
    bus_write(0, 16'h0010);
    run_idle(lc, bc);
    check("R6 status before abort", int'(bus_rdata), 16'h0008);

    // R8 reset wins over all; R10 abort mid-sequence
    bus_write(0, 16'h00B0);
    @(negedge clk);
    check("R8 reset wins", int'(bus_rdata & 16'h00B0), 16'h0080);
    #2;
    cycles(100);
    bus_write(4, 1);
    @(negedge clk);
    check("R10 ctrl after abort", int'(bus_rdata), 16'h0040);
    check("R10 line released", int'(ow_drive_low), 0);
    #2;
    bus_read(2, rd); check("R10 divider kept", rd, 4);

    // R8 no command bit
    bus_write(0, 16'h004F);
    @(negedge clk);
    check("R8 no command", int'(bus_rdata & 16'h00B0), 0);
    check("R8 line idle", int'(ow_drive_low), 0);
    #2;

    // R7 command landing on the completion edge
    bus_write(0, 16'h0020);
    repeat (348) @(posedge clk);
    bus_write(0, 16'h0010);
    @(negedge clk);
    check("R7 write on completion edge", int'(bus_rdata & 16'h00B0), 0);
    #2;
    bus_write(0, 16'h0010);
    @(negedge clk);
    check("R7 next write accepted", int'(bus_rdata & 16'h00B0), 16'h0010);
    #2;
    run_idle(lc, bc);

    // R2 time base at N = 50
    bus_write(2, 49);
    bus_write(0, 16'h0020);
    run_idle(lc, bc);
    check("R2 low length N=50", lc, 60 * 50);
    check("R2 busy length N=50", bc, 70 * 50);

    cycles(5);
    finish_up();
  end

endmodule